// File: doc/BRIEF.md
# Countdown Timer BCD Time Register

This block holds the time value of a kitchen-style countdown timer. A separate controller sends it one instruction per clock. The time is four BCD digits, written m:ss.t: a minutes digit, a tens-of-seconds digit, a units-of-seconds digit and a tenths digit. The controller edits minutes, tens and units one step per key press. It starts a countdown by storing the edited value as a preset, then sends one countdown step on every cycle gated by a 10 Hz tick.

When the countdown is cancelled or has expired, the controller sends the store instruction again. A store that follows a countdown step reloads the time from the preset; otherwise it captures the current time as the new preset. Both forms clear the tenths digit. The block drives the four digits for a display, with minutes leftmost, and a flag that is high when the time is exactly zero. The controller uses this flag to stop counting and raise the alarm.

Top module: `tmr_digit_core`

## Requirements
- R1: After reset the time reads 1:00.0 (digits_o = 16'h1000), zero_o is low, the preset holds 1:00 and no countdown is in progress.
- R2: op_i codes: 0 none, 1 store, 2 countdown step, 3/4 minutes up/down, 5/6 tens up/down, 7/8 units up/down. Code 0 and codes 9 to 15 leave the time, the preset and the countdown state unchanged.
- R3: Minutes up/down changes only the minutes digit (digits_o[15:12]) by one and wraps within 0 to 9.
- R4: Tens up/down changes only the tens-of-seconds digit (digits_o[11:8]) by one and wraps within 0 to 5.
- R5: Units up/down changes only the units-of-seconds digit (digits_o[7:4]) by one and wraps within 0 to 9, with no carry or borrow into tens.
- R6: A countdown step on a nonzero time subtracts one tenth (digits_o[3:0]). A digit at 0 borrows from the digit to its left and reloads with 9, or with 5 for tens.
- R7: A countdown step on time 0:00.0 leaves the time unchanged.
- R8: zero_o is high exactly when all four digits are zero, in the same cycle as the digits.
- R9: A store with no countdown step since reset, the last store or the last edit copies minutes, tens and units into the preset and clears tenths.
- R10: A store that follows one or more countdown steps, with no store or edit in between, reloads the time from the preset with tenths cleared. This holds also after the time has reached zero.
- R11: Any edit instruction ends the countdown-in-progress state, so the next store captures.
- R12: Each instruction's effect on digits_o and zero_o appears after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Instruction code for this cycle |
| digits_o | output | 16 | BCD time: [15:12] minutes, [11:8] tens, [7:4] units, [3:0] tenths |
| zero_o | output | 1 | High when the time is 0:00.0 |

## Verification
Every instruction takes effect at the single clock edge that samples it. The digits and the zero flag can therefore be read one edge later, because the zero flag is decoded from the digit registers without a further stage. The bench changes op_i on a falling edge and compares the outputs on the following falling edge, half a cycle after the register update, so every comparison sees exactly one instruction applied. Reset is checked while rst_n is still low, because the clear is asynchronous and needs no clock edge.

// File: rtl/tmr_digit_pkg.sv
package tmr_digit_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP     = 4'd0,
      OP_STORE   = 4'd1,
      OP_TICK    = 4'd2,
      OP_MIN_INC = 4'd3,
      OP_MIN_DEC = 4'd4,
      OP_TEN_INC = 4'd5,
      OP_TEN_DEC = 4'd6,
      OP_ONE_INC = 4'd7,
      OP_ONE_DEC = 4'd8
   } tmr_op_e;

   localparam int NDIG      = 4;
   localparam int IDX_TENTH = 0;
   localparam int IDX_ONE   = 1;
   localparam int IDX_TEN   = 2;
   localparam int IDX_MIN   = 3;

endpackage

// File: rtl/tmr_digit_cell.sv
module tmr_digit_cell #(
   parameter int W    = 4,
   parameter int TOP  = 9,
   parameter int RSTV = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         inc_en,
   input  logic         dec_en,
   output logic [W-1:0] cur,
   output logic         at_zero
);

   localparam logic [W-1:0] TOP_V = W'(TOP);
   localparam logic [W-1:0] RST_V = W'(RSTV);

   if (TOP >= (1 << W)) begin : g_bad_top
      $error("digit limit does not fit in the digit width");
   end
   if (RSTV > TOP) begin : g_bad_rst
      $error("digit reset value above digit limit");
   end

   logic [W-1:0] nxt;

   always_comb begin
      nxt = cur;
      if (load_en)
         nxt = load_val;
      else if (dec_en)
         nxt = (cur == '0) ? TOP_V : cur - 1'b1;
      else if (inc_en)
         nxt = (cur == TOP_V) ? '0 : cur + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= RST_V;
      else        cur <= nxt;
   end

   assign at_zero = (cur == '0);

   // R3 R4 R5: a digit never leaves its own range
   p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cur <= TOP_V);

endmodule

// File: rtl/tmr_borrow_chain.sv
module tmr_borrow_chain #(
   parameter int N = 4
) (
   input  logic         step,
   input  logic [N-1:0] zero_vec,
   output logic [N-1:0] dec_mask
);

   if (N < 2) begin : g_bad_n
      $error("borrow chain needs at least two digits");
   end

   assign dec_mask[0] = step;
   for (genvar g = 1; g < N; g++) begin : g_link
      assign dec_mask[g] = dec_mask[g-1] & zero_vec[g-1];
   end

endmodule

// File: rtl/tmr_preset_store.sv
module tmr_preset_store #(
   parameter int           W       = 12,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_en,
   input  logic [W-1:0] cap_d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_VAL;
      else if (cap_en) q <= cap_d;
   end

   // R2 R10: the preset only moves on a capture
   p_preset_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(q));

endmodule

// File: rtl/tmr_digit_core.sv
module tmr_digit_core
   import tmr_digit_pkg::*;
#(
   parameter int DIG_W     = 4,
   parameter int MIN_TOP   = 9,
   parameter int TEN_TOP   = 5,
   parameter int ONE_TOP   = 9,
   parameter int TENTH_TOP = 9,
   parameter int MIN_RST   = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [OP_W-1:0]       op_i,
   output logic [NDIG*DIG_W-1:0] digits_o,
   output logic                  zero_o
);

   localparam int TIME_W  = NDIG * DIG_W;
   localparam int PRE_W   = (NDIG - 1) * DIG_W;
   localparam int TOPS [NDIG] = '{TENTH_TOP, ONE_TOP, TEN_TOP, MIN_TOP};
   localparam int RSTS [NDIG] = '{0, 0, 0, MIN_RST};
   localparam logic [PRE_W-1:0] PRE_RST = {DIG_W'(MIN_RST), {(PRE_W-DIG_W){1'b0}}};

   if (DIG_W < 4) begin : g_bad_w
      $error("a BCD digit needs at least four bits");
   end

   tmr_op_e            op;
   logic               is_store, is_tick, running_q, any_edit, step;
   logic [NDIG-1:0]    ed_inc, ed_dec, zero_vec, tick_mask, ld_en;
   logic [DIG_W-1:0]   cur      [NDIG];
   logic [DIG_W-1:0]   ld_val   [NDIG];
   logic [PRE_W-1:0]   preset_q;

   assign op       = tmr_op_e'(op_i);
   assign is_store = (op == OP_STORE);
   assign is_tick  = (op == OP_TICK);

   always_comb begin
      ed_inc = '0;
      ed_dec = '0;
      unique case (op)
         OP_MIN_INC: ed_inc[IDX_MIN] = 1'b1;
         OP_MIN_DEC: ed_dec[IDX_MIN] = 1'b1;
         OP_TEN_INC: ed_inc[IDX_TEN] = 1'b1;
         OP_TEN_DEC: ed_dec[IDX_TEN] = 1'b1;
         OP_ONE_INC: ed_inc[IDX_ONE] = 1'b1;
         OP_ONE_DEC: ed_dec[IDX_ONE] = 1'b1;
         default: ;
      endcase
   end
   assign any_edit = |{ed_inc, ed_dec};

   // countdown-in-progress: set by a step, cleared by store or edit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     running_q <= 1'b0;
      else if (is_tick)               running_q <= 1'b1;
      else if (is_store || any_edit)  running_q <= 1'b0;
   end

   assign zero_o = &zero_vec;
   assign step   = is_tick & ~zero_o;

   tmr_borrow_chain #(.N(NDIG)) chain_i (
      .step     (step),
      .zero_vec (zero_vec),
      .dec_mask (tick_mask)
   );

   tmr_preset_store #(.W(PRE_W), .RST_VAL(PRE_RST)) preset_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (is_store & ~running_q),
      .cap_d  (digits_o[TIME_W-1:DIG_W]),
      .q      (preset_q)
   );

   for (genvar g = 0; g < NDIG; g++) begin : g_dig
      if (g == IDX_TENTH) begin : g_tenth
         assign ld_en[g]  = is_store;
         assign ld_val[g] = '0;
      end else begin : g_edit
         assign ld_en[g]  = is_store & running_q;
         assign ld_val[g] = preset_q[(g-1)*DIG_W +: DIG_W];
      end

      tmr_digit_cell #(.W(DIG_W), .TOP(TOPS[g]), .RSTV(RSTS[g])) cell_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_en  (ld_en[g]),
         .load_val (ld_val[g]),
         .inc_en   (ed_inc[g]),
         .dec_en   (ed_dec[g] | tick_mask[g]),
         .cur      (cur[g]),
         .at_zero  (zero_vec[g])
      );

      assign digits_o[g*DIG_W +: DIG_W] = cur[g];
   end

   localparam logic [DIG_W-1:0] MIN_TOP_V = DIG_W'(MIN_TOP);
   wire [DIG_W-1:0] min_d   = digits_o[IDX_MIN*DIG_W +: DIG_W];
   wire [DIG_W-1:0] tenth_d = digits_o[DIG_W-1:0];

   p_nop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NOP) |=> $stable(digits_o));

   p_min_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MIN_INC) |=>
         min_d == (($past(min_d) == MIN_TOP_V) ? '0 : $past(min_d) + 1'b1));

   p_tick_tenth_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_tick && tenth_d != '0) |=> tenth_d == $past(tenth_d) - 1'b1);

   p_tick_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_tick && zero_o) |=> $stable(digits_o));

   p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o |-> (digits_o == '0));

   p_store_tenth_r9: assert property (@(posedge clk) disable iff (!rst_n)
      is_store |=> (tenth_d == '0));

   p_edit_ends_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      any_edit |=> !running_q);

endmodule

// File: tb/tmr_digit_core_tb.sv
`timescale 1ns/1ps
module tmr_digit_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = 4'd0;
   logic [15:0] digits_o;
   logic        zero_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tmr_digit_core dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op_i),
      .digits_o (digits_o),
      .zero_o   (zero_o)
   );

   localparam logic [3:0] NOP = 4'd0, STO = 4'd1, TCK = 4'd2,
      MIU = 4'd3, MID = 4'd4, TEU = 4'd5, TED = 4'd6, ONU = 4'd7, OND = 4'd8;

   // {op, expected digits, expected zero}
   localparam int NVEC = 17;
   localparam logic [20:0] VEC [NVEC] = '{
      {NOP,   16'h1000, 1'b0},  // R2 none
      {4'hF,  16'h1000, 1'b0},  // R2 unused code
      {MIU,   16'h2000, 1'b0},  // R3
      {MID,   16'h1000, 1'b0},  // R3
      {MID,   16'h0000, 1'b1},  // R3 R8
      {MID,   16'h9000, 1'b0},  // R3 wrap down
      {MIU,   16'h0000, 1'b1},  // R3 wrap up
      {TED,   16'h0500, 1'b0},  // R4 wrap down
      {TEU,   16'h0000, 1'b1},  // R4 wrap up
      {OND,   16'h0090, 1'b0},  // R5 wrap, no borrow
      {ONU,   16'h0000, 1'b1},  // R5 no carry
      {ONU,   16'h0010, 1'b0},  // R5
      {STO,   16'h0010, 1'b0},  // R9 capture 0:01
      {TCK,   16'h0009, 1'b0},  // R6 borrow units
      {TCK,   16'h0008, 1'b0},  // R6
      {STO,   16'h0010, 1'b0},  // R10 restore
      {STO,   16'h0010, 1'b0}   // R9 capture again
   };

   task automatic check(input logic [15:0] exp_d, input logic exp_z, input string req);
      checks++;
      if (digits_o !== exp_d || zero_o !== exp_z) begin
         errors++;
         $display("FAIL %s: digits=%h zero=%b expected digits=%h zero=%b",
                  req, digits_o, zero_o, exp_d, exp_z);
      end
   endtask

   task automatic do_op(input logic [3:0] op, input logic [15:0] exp_d,
                        input logic exp_z, input string req);
      op_i = op;
      @(negedge clk);
      check(exp_d, exp_z, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      check(16'h1000, 1'b0, "R1 reset value");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++)
         do_op(VEC[i][20:17], VEC[i][16:1], VEC[i][0], "R12 vector table");

      // run 0:01.0 down to zero
      for (int i = 0; i < 9; i++) do_op(TCK, 16'h0009 - 16'(i), 1'b0, "R6 countdown");
      do_op(TCK, 16'h0000, 1'b1, "R8 reached zero");
      do_op(TCK, 16'h0000, 1'b1, "R7 hold at zero");
      do_op(STO, 16'h0010, 1'b0, "R10 restore after expiry");

      // full borrow chain from 1:00.0
      do_op(OND, 16'h0000, 1'b1, "R5 edit");
      do_op(MIU, 16'h1000, 1'b0, "R3 edit");
      do_op(TCK, 16'h0599, 1'b0, "R6 borrow into minutes");
      do_op(TCK, 16'h0598, 1'b0, "R6");
      do_op(MIU, 16'h1598, 1'b0, "R11 edit during run");
      do_op(STO, 16'h1590, 1'b0, "R11 store captures after edit");
      do_op(TCK, 16'h1589, 1'b0, "R6 borrow tenths");
      do_op(STO, 16'h1590, 1'b0, "R10 restore preset");
      do_op(4'd12, 16'h1590, 1'b0, "R2 unused code");

      // mid-run reset, preset back to 1:00
      rst_n = 1'b0;
      op_i  = NOP;
      #1;
      check(16'h1000, 1'b0, "R1 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      do_op(TCK, 16'h0599, 1'b0, "R6 after reset");
      do_op(STO, 16'h1000, 1'b0, "R1 preset default restored");

      finish_run();
   end

endmodule